// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block runs on the host side of a parallel flash part. It decides when a program or erase operation inside the part has finished. After software has issued the operation, a single `start` pulse hands control to the poller. The poller then issues read cycles to one poll address. It watches one status bit that flips on every read while the part is busy. It also watches a timeout bit, bit 5 of the read data.

Reads are taken in pairs. If the watched bit holds its value across a pair, the operation is complete and the poller reports pass. The next read of the part then returns array data.

If the bit is still flipping but the timeout bit of the newer read is set, the poller takes one more confirming pair. This catches a bit that stopped just as the timeout rose. If the bit still flips on that pair, the poller writes the reset command to the part and reports fail. A parameter caps the number of ordinary polling pairs, so a part that never settles also ends in the reset write and fail. An abort input drops the run at any point without a result.

The bus side is a request channel with valid/ready semantics. The poller raises `bus_valid` and holds it, with address, direction and write data unchanged, until the bus accepts with `bus_ready`. Back-pressure is applied only by holding `bus_ready` low, for as many cycles as the bus needs. Read data is sampled in the accepting cycle.

Top module: `toggle_poll_ctrl`

## Requirements
- R1: A bus transfer takes place in a cycle where `bus_valid` and `bus_ready` are both high. While `bus_valid` is high and `bus_ready` is low (and no abort), `bus_valid`, `bus_write`, `bus_addr` and `bus_wdata` keep their values into the next cycle. Reads use `bus_write`=0 and the `poll_addr` captured at start.
- R2: If the watched bit has the same value in both reads of a polling pair, the run ends with pass after exactly those reads.
- R3: If the watched bit differs within a pair and bit 5 of the second read is 1, the poller issues a confirming pair of reads. Bit 5 of the first read of the pair has no bearing on this choice.
- R4: If the watched bit is equal across the confirming pair, the run ends with pass.
- R5: If the watched bit differs within a pair and bit 5 of the second read is 0, a new pair starts. Its first read is stored afresh and is not compared with any earlier read.
- R6: If the watched bit differs within the confirming pair, the poller issues exactly one write (`bus_write`=1) of 0xF0 to the poll address. Fail is reported only in the cycle after that write is accepted.
- R7: With `sel_q2`=0 the watched bit is read data bit 6. With `sel_q2`=1 it is bit 2. The bit that is not selected has no effect.
- R8: `abort` has priority over every other input. In the cycle after an abort, `bus_valid` and `done` are low. A later start begins with a fresh first read.
- R9: When the MAX_POLLS-th ordinary pair still differs with bit 5 low, the poller issues the reset write of R6 and reports fail.
- R10: `start` is taken only when the poller is idle. Once taken, the first read request is raised in the next cycle and `pass`/`fail` are cleared. `start` while busy has no effect.
- R11: `done` is high for exactly one cycle, the cycle after the final transfer. `pass` and `fail` are never both high, and they hold their values until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a polling run (taken when idle) |
| sel_q2 | input | 1 | Watched bit: 0 selects bit 6, 1 selects bit 2 |
| abort | input | 1 | Abandon the run and return to idle |
| poll_addr | input | AW | Address polled and used for the reset write |
| bus_valid | output | 1 | Bus request valid |
| bus_ready | input | 1 | Bus accepts the request this cycle |
| bus_write | output | 1 | 1 = write, 0 = read |
| bus_addr | output | AW | Request address |
| bus_wdata | output | 8 | Write data (reset command) |
| bus_rdata | input | 8 | Read data, sampled when the read is accepted |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Run ended with the operation complete |
| fail | output | 1 | Run ended with the reset write issued |

## Verification
The bench builds the poller with MAX_POLLS=4 and an 8-bit address. The poll budget is therefore used up after eight reads, so the path where the budget runs out and ends in the reset write and fail is reached in a short run, next to the normal pass paths. The bus latency is varied from zero to two cycles, so back-to-back acceptance and held requests both occur. Runs include both watched-bit selections, a timeout bit set only on the first read of a pair, an abort followed by a restart, and a start while busy.

// File: rtl/tpoll_pkg.sv
package tpoll_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RD_A  = 3'd1,
    ST_RD_B  = 3'd2,
    ST_CHK_A = 3'd3,
    ST_CHK_B = 3'd4,
    ST_RST_WR = 3'd5
  } tpoll_state_e;

  typedef struct packed {
    logic tbit;
    logic tmo;
  } tpoll_sample_t;

  localparam logic [7:0] RESET_CMD = 8'hF0;

endpackage

// File: rtl/tpoll_tap.sv
module tpoll_tap
  import tpoll_pkg::*;
#(
  parameter int DW      = 8,
  parameter int POS_A   = 6,
  parameter int POS_B   = 2,
  parameter int POS_TMO = 5
) (
  input  logic [DW-1:0] rdata,
  input  logic          sel_b,
  output tpoll_sample_t sample
);
  logic tap_unused;

  assign sample.tbit = sel_b ? rdata[POS_B] : rdata[POS_A];
  assign sample.tmo  = rdata[POS_TMO];
  assign tap_unused  = ^rdata;
endmodule

// File: rtl/tpoll_cmp.sv
module tpoll_cmp (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic cur_bit,
  output logic toggled
);
  logic first_q;

  always_ff @(posedge clk) begin
    if (!rst_n) first_q <= 1'b0;
    else if (load) first_q <= cur_bit;
  end

  assign toggled = first_q ^ cur_bit;
endmodule

// File: rtl/tpoll_budget.sv
module tpoll_budget #(
  parameter int MAX_POLLS = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic bump,
  output logic last
);
  localparam int CW = $clog2(MAX_POLLS + 1);
  localparam logic [CW-1:0] LAST_VAL = CW'(MAX_POLLS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else if (clear) cnt_q <= '0;
    else if (bump) cnt_q <= cnt_q + 1'b1;
  end

  assign last = (cnt_q == LAST_VAL);
endmodule

// File: rtl/toggle_poll_ctrl.sv
module toggle_poll_ctrl
  import tpoll_pkg::*;
#(
  parameter int AW        = 20,
  parameter int MAX_POLLS = 1024
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          sel_q2,
  input  logic          abort,
  input  logic [AW-1:0] poll_addr,
  output logic          bus_valid,
  input  logic          bus_ready,
  output logic          bus_write,
  output logic [AW-1:0] bus_addr,
  output logic [7:0]    bus_wdata,
  input  logic [7:0]    bus_rdata,
  output logic          done,
  output logic          pass,
  output logic          fail
);
  tpoll_state_e  state_q;
  logic [AW-1:0] addr_q;
  logic          sel_q;
  tpoll_sample_t smp;
  logic          xfer, toggled, budget_last;
  logic          load_first, bump_budget, clear_budget;

  assign bus_valid = (state_q != ST_IDLE);
  assign bus_write = (state_q == ST_RST_WR);
  assign bus_addr  = addr_q;
  assign bus_wdata = bus_write ? RESET_CMD : 8'h00;
  assign xfer      = bus_valid && bus_ready && !abort;

  tpoll_tap #(.DW(8), .POS_A(6), .POS_B(2), .POS_TMO(5)) u_tap (
    .rdata (bus_rdata),
    .sel_b (sel_q),
    .sample(smp)
  );

  assign load_first = xfer && (state_q == ST_RD_A || state_q == ST_CHK_A);

  tpoll_cmp u_cmp (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load_first),
    .cur_bit(smp.tbit),
    .toggled(toggled)
  );

  assign clear_budget = (state_q == ST_IDLE) && start && !abort;
  assign bump_budget  = xfer && (state_q == ST_RD_B) && toggled && !smp.tmo;

  tpoll_budget #(.MAX_POLLS(MAX_POLLS)) u_budget (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(clear_budget),
    .bump (bump_budget),
    .last (budget_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      sel_q   <= 1'b0;
      done    <= 1'b0;
      pass    <= 1'b0;
      fail    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (abort) begin
        state_q <= ST_IDLE;
      end else begin
        unique case (state_q)
          ST_IDLE: if (start) begin
            state_q <= ST_RD_A;
            addr_q  <= poll_addr;
            sel_q   <= sel_q2;
            pass    <= 1'b0;
            fail    <= 1'b0;
          end
          ST_RD_A: if (xfer) state_q <= ST_RD_B;
          ST_RD_B: if (xfer) begin
            if (!toggled) begin
              state_q <= ST_IDLE;
              done    <= 1'b1;
              pass    <= 1'b1;
            end else if (smp.tmo) begin
              state_q <= ST_CHK_A;
            end else if (budget_last) begin
              state_q <= ST_RST_WR;
            end else begin
              state_q <= ST_RD_A;
            end
          end
          ST_CHK_A: if (xfer) state_q <= ST_CHK_B;
          ST_CHK_B: if (xfer) begin
            if (!toggled) begin
              state_q <= ST_IDLE;
              done    <= 1'b1;
              pass    <= 1'b1;
            end else begin
              state_q <= ST_RST_WR;
            end
          end
          ST_RST_WR: if (xfer) begin
            state_q <= ST_IDLE;
            done    <= 1'b1;
            fail    <= 1'b1;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/tpoll_checker.sv
module tpoll_checker #(
  parameter int AW        = 20,
  parameter int MAX_POLLS = 1024
) (
  input logic          clk,
  input logic          rst_n,
  input logic          abort,
  input logic          bus_valid,
  input logic          bus_ready,
  input logic          bus_write,
  input logic [AW-1:0] bus_addr,
  input logic [7:0]    bus_wdata,
  input logic          done,
  input logic          pass,
  input logic          fail
);
  localparam int RD_CAP = 2 * MAX_POLLS + 2;
  int unsigned rd_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !bus_valid) rd_cnt <= 0;
    else if (bus_ready && !bus_write && !abort) rd_cnt <= rd_cnt + 1;
  end

  p_hold_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready && !abort) |=> (bus_valid && $stable(bus_addr)
      && $stable(bus_write) && $stable(bus_wdata)));

  p_wr_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write) |-> (bus_wdata == 8'hF0));

  p_fail_after_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> $past(bus_valid && bus_write && bus_ready && !abort));

  p_abort_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!bus_valid && !done));

  p_read_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cnt <= RD_CAP);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_flag_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass && fail));

  p_done_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pass != fail));
endmodule

bind toggle_poll_ctrl tpoll_checker #(.AW(AW), .MAX_POLLS(MAX_POLLS)) u_tpoll_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .abort    (abort),
  .bus_valid(bus_valid),
  .bus_ready(bus_ready),
  .bus_write(bus_write),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .done     (done),
  .pass     (pass),
  .fail     (fail)
);

// File: tb/test_toggle_poll_ctrl.sv
`timescale 1ns/1ps
module test_toggle_poll_ctrl;
  localparam int AW = 8;
  localparam int MAXP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, sel_q2 = 1'b0, abort = 1'b0;
  logic [AW-1:0] poll_addr = '0;
  logic bus_valid, bus_ready = 1'b0, bus_write;
  logic [AW-1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata = 8'h00;
  logic done, pass, fail;

  always #2 clk = ~clk;

  toggle_poll_ctrl #(.AW(AW), .MAX_POLLS(MAXP)) i_toggle_poll_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .sel_q2(sel_q2), .abort(abort),
    .poll_addr(poll_addr), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .done(done), .pass(pass), .fail(fail)
  );

  int checks = 0, errors = 0;
  logic [7:0] rq[$];
  int lat = 0, wcnt = 0, nreads = 0, nwrites = 0;
  // reference model: 0 idle, 1 read first, 2 read second, 3 confirm first,
  // 4 confirm second, 5 reset write
  int m_state = 0, m_pairs = 0;
  bit m_first = 0, m_done = 0, m_pass = 0, m_fail = 0, m_sel = 0;
  logic [AW-1:0] m_addr = '0;
  bit finished = 0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit wbit(logic [7:0] d, bit s);
    return s ? d[2] : d[6];
  endfunction

  task automatic cyc();
    bit ev, x, tg;
    int ns, np; bit nf1, nd, npass, nfail, nsel;
    logic [AW-1:0] naddr;
    ev = (m_state != 0);
    bus_ready = ev && (wcnt >= lat);
    bus_rdata = (rq.size() > 0) ? rq[0] : 8'h00;
    x = ev && bus_ready && !abort;
    ns = m_state; np = m_pairs; nf1 = m_first; nd = 0;
    npass = m_pass; nfail = m_fail; naddr = m_addr; nsel = m_sel;
    tg = wbit(bus_rdata, m_sel) != m_first;
    if (abort) ns = 0;
    else case (m_state)
      0: if (start) begin ns = 1; np = 0; npass = 0; nfail = 0; naddr = poll_addr; nsel = sel_q2; end
      1: if (x) begin nf1 = wbit(bus_rdata, m_sel); ns = 2; end
      2: if (x) begin
        if (!tg) begin ns = 0; nd = 1; npass = 1; end
        else if (bus_rdata[5]) ns = 3;
        else if (m_pairs == MAXP - 1) ns = 5;
        else begin np = m_pairs + 1; ns = 1; end
      end
      3: if (x) begin nf1 = wbit(bus_rdata, m_sel); ns = 4; end
      4: if (x) begin
        if (!tg) begin ns = 0; nd = 1; npass = 1; end else ns = 5;
      end
      5: if (x) begin ns = 0; nd = 1; nfail = 1; end
      default: ns = 0;
    endcase
    if (x && m_state != 5) begin void'(rq.pop_front()); nreads++; end
    if (x && m_state == 5) nwrites++;
    if (!ev || x || abort) wcnt = 0; else wcnt++;
    @(posedge clk); #1;
    m_state = ns; m_pairs = np; m_first = nf1; m_done = nd;
    m_pass = npass; m_fail = nfail; m_addr = naddr; m_sel = nsel;
    chk("R1", "bus_valid", bus_valid, m_state != 0);
    if (m_state != 0) begin
      chk("R1", "bus_write", bus_write, m_state == 5);
      chk("R1", "bus_addr", bus_addr, m_addr);
      if (m_state == 5) chk("R6", "bus_wdata", bus_wdata, 8'hF0);
    end
    chk("R11", "done", done, m_done);
    chk("R11", "pass", pass, m_pass);
    chk("R11", "fail", fail, m_fail);
  endtask

  task automatic run(string req, bit sel, logic [AW-1:0] a, int l,
                     logic [7:0] d[$], bit exp_pass, int exp_reads, bit poke_start);
    bit got_done;
    rq = d; lat = l; nreads = 0; nwrites = 0; got_done = 0;
    sel_q2 = sel; poll_addr = a; start = 1'b1;
    cyc();
    start = 1'b0;
    for (int i = 0; i < 80 && !got_done; i++) begin
      if (poke_start && i == 1) begin start = 1'b1; sel_q2 = ~sel; poll_addr = ~a; end
      cyc();
      start = 1'b0;
      got_done = done;
    end
    chk(req, "run ended", got_done, 1);
    chk(req, "pass flag", pass, exp_pass);
    chk(req, "fail flag", fail, !exp_pass);
    chk(req, "read count", nreads, exp_reads);
    chk(req, "write count", nwrites, exp_pass ? 0 : 1);
    cyc();
    chk("R11", "flag held", pass, exp_pass);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk("R11", "reset done", done, 0);
    chk("R11", "reset pass", pass, 0);
    chk("R11", "reset fail", fail, 0);
    chk("R1", "reset bus_valid", bus_valid, 0);
    cyc();
    // R2: settled on first pair, bit 6 watched; start while busy ignored (R10)
    run("R2", 0, 8'h11, 0, '{8'h40, 8'h40}, 1, 2, 0);
    run("R10", 0, 8'h12, 2, '{8'h00, 8'h40, 8'h40, 8'h40}, 1, 4, 1);
    // R5: toggling with bit 5 low, then settled
    run("R5", 0, 8'h21, 1, '{8'h40, 8'h00, 8'h00, 8'h00}, 1, 4, 0);
    // R3: bit 5 high on first read only -> plain new pairs
    run("R3", 0, 8'h22, 0, '{8'h60, 8'h00, 8'h00, 8'h40, 8'h40, 8'h40}, 1, 6, 0);
    // R4: confirm pair settled
    run("R4", 0, 8'h31, 1, '{8'h00, 8'h60, 8'h20, 8'h20}, 1, 4, 0);
    // R6: confirm pair still toggling -> reset write and fail
    run("R6", 0, 8'h32, 2, '{8'h00, 8'h60, 8'h60, 8'h20}, 0, 4, 0);
    // R7: bit 2 watched, bit 6 toggling is ignored
    run("R7", 1, 8'h41, 0, '{8'h40, 8'h00}, 1, 2, 0);
    run("R7", 1, 8'h42, 1, '{8'h00, 8'h44, 8'h04, 8'h04}, 1, 4, 0);
    // R9: budget exhausted
    run("R9", 0, 8'h51, 0, '{8'h00, 8'h40, 8'h40, 8'h00, 8'h00, 8'h40, 8'h40, 8'h00}, 0, 8, 0);
    // R8: abort mid-run then fresh restart
    rq = '{8'h40}; lat = 0; sel_q2 = 1'b0; poll_addr = 8'h61; start = 1'b1;
    cyc(); start = 1'b0;
    cyc();
    abort = 1'b1; cyc(); abort = 1'b0;
    chk("R8", "valid after abort", bus_valid, 0);
    chk("R8", "done after abort", done, 0);
    cyc();
    run("R8", 0, 8'h62, 0, '{8'h00, 8'h00}, 1, 2, 0);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule